// File: doc/BRIEF.md
# Paced Word Memory Port with Bus Arbitration

This block sits between a remote terminal's protocol controller and a word-wide memory or peripheral. The controller hands it one transfer at a time: a direction (read or write), the transmit/receive flag of the current command, its subaddress, the index of the data word within the message and, for writes, the data. The block turns that into a memory address and asks for the shared bus with a request line. It drives a read or write strobe once the grant arrives, and lowers the request again as soon as the transfer ends.

Transfers are rationed. A pacing counter allows at most one new bus request per `PACE` clock cycles; with the defaults, one transfer every 100 cycles of a 50 MHz clock, or one every 2 µs. A slow device may hold any strobe open with its wait input. A build-time parameter picks between a synchronous device, where the strobe lasts one cycle and read data is sampled a cycle later, and an asynchronous device, where the strobe is held for a minimum number of cycles. The controller can queue one transfer while another is still in progress, and a busy flag tells it that the queue slot is taken.

Top module: `paced_mem_port`

## Requirements
- R1: While reset is asserted and directly after it, `bus_req`, `mem_rd`, `mem_wr`, `busy` and `done` are all low.
- R2: The memory address is `{xfer_tr, xfer_sa, xfer_wc}`: the transmit/receive flag at bit 10, the subaddress at bits 9:5 and the word index at bits 4:0. It holds steady for the whole strobe.
- R3: A strobe only starts after `bus_gnt` has been sampled high while `bus_req` is high. The strobe rises in the cycle after the grant is sampled, so with a grant that arrives `g` cycles after the request rises, the strobe rises `g+1` cycles after the request.
- R4: Two rising edges of `bus_req` are at least `PACE` cycles apart. When a transfer is already queued, the gap is exactly `PACE` cycles.
- R5: In synchronous mode (`ASYNC_MODE=0`), the strobe is high for one cycle plus one more cycle for each cycle that `mem_wait` is high during it. Read data is sampled in the cycle after the strobe ends.
- R6: In asynchronous mode (`ASYNC_MODE=1`), the strobe stays high for at least `STROBE_MIN` cycles (4 by default) and after that for as long as `mem_wait` is high. Read data is sampled at the edge that ends the strobe.
- R7: `bus_req` is low in the first cycle after the strobe ends.
- R8: A one-cycle `xfer_valid` pulse is taken into a one-entry slot when that slot is empty, and `busy` is high while the slot holds a transfer. A pulse that arrives while `busy` is high is dropped and never reaches the memory.
- R9: `done` pulses for one cycle for each finished transfer. After a read, `rdata` holds the word the device returned. During a write strobe, `mem_wdata` carries the queued data.
- R10: `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_valid | input | 1 | One-cycle request for a transfer |
| xfer_write | input | 1 | 1 = write, 0 = read |
| xfer_tr | input | 1 | Transmit/receive flag of the command |
| xfer_sa | input | 5 | Subaddress |
| xfer_wc | input | 5 | Word index within the message |
| xfer_wdata | input | 16 | Write data |
| busy | output | 1 | Queue slot is occupied; new requests are dropped |
| done | output | 1 | One-cycle pulse when a transfer finishes |
| rdata | output | 16 | Last word read |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| mem_wait | input | 1 | Device not ready; stretches the strobe |
| mem_addr | output | 11 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |

## Verification
A pacing counter left in a wrong state shows up as a change in the spacing between two `bus_req` rises. That spacing can be seen at the very next queued transfer, at most `PACE` cycles later. A strobe-length counter or a wait decision that goes wrong changes the number of strobe cycles, or changes which cycle the read data is sampled in, within the same transfer. A queue slot that fails to fill or to empty shows as a `busy` flag in the wrong cycle, a lost transfer, or an extra one in the count of strobes.

// File: rtl/paced_mem_port.sv
module paced_mem_port #(
  parameter int SA_W       = 5,
  parameter int WC_W       = 5,
  parameter int DW         = 16,
  parameter int PACE       = 100,
  parameter int ASYNC_MODE = 0,
  parameter int STROBE_MIN = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    xfer_valid,
  input  logic                    xfer_write,
  input  logic                    xfer_tr,
  input  logic [SA_W-1:0]         xfer_sa,
  input  logic [WC_W-1:0]         xfer_wc,
  input  logic [DW-1:0]           xfer_wdata,
  output logic                    busy,
  output logic                    done,
  output logic [DW-1:0]           rdata,
  output logic                    bus_req,
  input  logic                    bus_gnt,
  input  logic                    mem_wait,
  output logic [SA_W+WC_W:0]      mem_addr,
  output logic [DW-1:0]           mem_wdata,
  input  logic [DW-1:0]           mem_rdata,
  output logic                    mem_rd,
  output logic                    mem_wr
);
  localparam int AW   = 1 + SA_W + WC_W;
  localparam int PW   = $clog2(PACE + 1);
  localparam int MINS = (ASYNC_MODE != 0) ? STROBE_MIN : 1;
  localparam int SCW  = $clog2(MINS + 1) + 1;

  typedef enum logic [1:0] {S_IDLE, S_ARB, S_XFER, S_FIN} st_t;
  st_t st;

  logic [PW-1:0]  pace;
  logic [SCW-1:0] sc;
  logic           slot_v, slot_w, cur_w;
  logic [AW-1:0]  slot_addr;
  logic [DW-1:0]  slot_data;

  wire accept   = xfer_valid && !slot_v;
  wire launch   = (st == S_IDLE) && slot_v && (pace == '0);
  wire xfer_end = (st == S_XFER) && (sc >= SCW'(MINS - 1)) && !mem_wait;
  wire strobe   = (st == S_XFER);

  assign busy    = slot_v;
  assign bus_req = (st == S_ARB) || (st == S_XFER);
  assign mem_rd  = strobe && !cur_w;
  assign mem_wr  = strobe && cur_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v    <= 1'b0;
      slot_w    <= 1'b0;
      slot_addr <= '0;
      slot_data <= '0;
    end else if (launch) begin
      slot_v <= 1'b0;
    end else if (accept) begin
      slot_v    <= 1'b1;
      slot_w    <= xfer_write;
      slot_addr <= {xfer_tr, xfer_sa, xfer_wc};
      slot_data <= xfer_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      pace      <= '0;
      sc        <= '0;
      cur_w     <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
    end else begin
      done <= (st == S_FIN);
      if (launch)
        pace <= PW'(PACE - 1);
      else if (pace != '0)
        pace <= pace - 1'b1;
      if (st != S_XFER)
        sc <= '0;
      else if (sc < SCW'(MINS - 1))
        sc <= sc + 1'b1;
      case (st)
        S_IDLE: if (launch) begin
          st        <= S_ARB;
          cur_w     <= slot_w;
          mem_addr  <= slot_addr;
          mem_wdata <= slot_data;
        end
        S_ARB:  if (bus_gnt) st <= S_XFER;
        S_XFER: if (xfer_end) st <= S_FIN;
        default: st <= S_IDLE;
      endcase
    end
  end

  generate
    if (ASYNC_MODE != 0) begin : g_async_cap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata <= '0;
        else if (xfer_end && !cur_w) rdata <= mem_rdata;
      end
    end else begin : g_sync_cap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata <= '0;
        else if (st == S_FIN && !cur_w) rdata <= mem_rdata;
      end
    end
  endgenerate

  logic          req_q;
  logic [PW-1:0] gap;
  logic [SCW-1:0] sw;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      gap   <= PW'(PACE);
      sw    <= '0;
    end else begin
      req_q <= bus_req;
      if (bus_req && !req_q) gap <= PW'(1);
      else if (gap < PW'(PACE)) gap <= gap + 1'b1;
      if (mem_rd || mem_wr) begin
        if (sw < SCW'(MINS)) sw <= sw + 1'b1;
      end else sw <= '0;
    end
  end

  assert_rdwr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  assert_strobe_in_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> bus_req);
  assert_strobe_after_gnt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd || mem_wr) |-> $past(bus_gnt));
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && $past(mem_rd || mem_wr)) |-> $stable(mem_addr));
  assert_req_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd || mem_wr) |-> !bus_req);
  assert_pace_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !req_q) |-> (gap >= PW'(PACE)));
  assert_strobe_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd || mem_wr) |-> (sw >= SCW'(MINS)));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/paced_mem_port_bench.sv
module dev_model (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        mem_rd,
  input  logic        mem_wr,
  input  logic [10:0] addr,
  input  logic [15:0] wdata,
  input  logic [3:0]  gdel,
  input  logic [3:0]  waitn,
  output logic        bus_gnt,
  output logic        mem_wait,
  output logic [15:0] rdata,
  output logic [7:0]  last_len,
  output logic [7:0]  last_lat,
  output int          n_acc,
  output logic [10:0] cap_addr,
  output logic [10:0] last_waddr,
  output logic [15:0] last_wdata,
  output logic        bad_strobe,
  output logic        req_bad,
  output logic        both
);
  logic [3:0] gcnt, wcnt;
  logic [7:0] scnt, lcnt;
  wire strobe = mem_rd || mem_wr;
  assign bus_gnt  = bus_req && (gcnt >= gdel);
  assign mem_wait = strobe && (wcnt < waitn);
  assign rdata    = ({5'd0, addr} * 16'd37) ^ 16'h5A3C;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcnt <= '0; wcnt <= '0; scnt <= '0; lcnt <= '0;
      last_len <= '0; last_lat <= '0; n_acc <= 0; cap_addr <= '0;
      last_waddr <= '0; last_wdata <= '0;
      bad_strobe <= 1'b0; req_bad <= 1'b0; both <= 1'b0;
    end else begin
      gcnt <= bus_req ? ((gcnt == 4'hF) ? gcnt : gcnt + 1'b1) : 4'd0;
      wcnt <= strobe ? ((wcnt == 4'hF) ? wcnt : wcnt + 1'b1) : 4'd0;
      lcnt <= !bus_req ? 8'd0 : (!strobe ? lcnt + 1'b1 : lcnt);
      if (strobe) begin
        scnt <= scnt + 1'b1;
        if (scnt == 0) begin
          cap_addr <= addr;
          last_lat <= lcnt;
        end
      end else if (scnt != 0) begin
        last_len <= scnt;
        n_acc    <= n_acc + 1;
        scnt     <= '0;
        if (bus_req) req_bad <= 1'b1;
      end
      if (mem_wr && !mem_wait) begin
        last_waddr <= addr;
        last_wdata <= wdata;
      end
      if (strobe && !bus_gnt) bad_strobe <= 1'b1;
      if (mem_rd && mem_wr) both <= 1'b1;
    end
  end
endmodule

module paced_mem_port_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, xfer_valid, xfer_write, xfer_tr;
  logic [4:0] xfer_sa, xfer_wc;
  logic [15:0] xfer_wdata;
  logic [3:0] gdel, waitn;

  logic busy_s, done_s, breq_s, gnt_s, wait_s, rd_s, wr_s;
  logic [15:0] rdata_s, wd_s, mrd_s;
  logic [10:0] addr_s;
  logic busy_a, done_a, breq_a, gnt_a, wait_a, rd_a, wr_a;
  logic [15:0] rdata_a, wd_a, mrd_a;
  logic [10:0] addr_a;

  logic [7:0] len_s, lat_s, len_a, lat_a;
  int acc_s, acc_a;
  logic [10:0] cap_s, cap_a, wa_s, wa_a;
  logic [15:0] wdv_s, wdv_a;
  logic bad_s, bad_a, rqb_s, rqb_a, both_s, both_a;

  paced_mem_port #(.ASYNC_MODE(0)) u_paced_mem_port (
    .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_write(xfer_write),
    .xfer_tr(xfer_tr), .xfer_sa(xfer_sa), .xfer_wc(xfer_wc), .xfer_wdata(xfer_wdata),
    .busy(busy_s), .done(done_s), .rdata(rdata_s), .bus_req(breq_s), .bus_gnt(gnt_s),
    .mem_wait(wait_s), .mem_addr(addr_s), .mem_wdata(wd_s), .mem_rdata(mrd_s),
    .mem_rd(rd_s), .mem_wr(wr_s));
  paced_mem_port #(.ASYNC_MODE(1)) u_paced_mem_port_async (
    .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_write(xfer_write),
    .xfer_tr(xfer_tr), .xfer_sa(xfer_sa), .xfer_wc(xfer_wc), .xfer_wdata(xfer_wdata),
    .busy(busy_a), .done(done_a), .rdata(rdata_a), .bus_req(breq_a), .bus_gnt(gnt_a),
    .mem_wait(wait_a), .mem_addr(addr_a), .mem_wdata(wd_a), .mem_rdata(mrd_a),
    .mem_rd(rd_a), .mem_wr(wr_a));

  dev_model m_s (.clk(clk), .rst_n(rst_n), .bus_req(breq_s), .mem_rd(rd_s), .mem_wr(wr_s),
    .addr(addr_s), .wdata(wd_s), .gdel(gdel), .waitn(waitn), .bus_gnt(gnt_s),
    .mem_wait(wait_s), .rdata(mrd_s), .last_len(len_s), .last_lat(lat_s), .n_acc(acc_s),
    .cap_addr(cap_s), .last_waddr(wa_s), .last_wdata(wdv_s), .bad_strobe(bad_s),
    .req_bad(rqb_s), .both(both_s));
  dev_model m_a (.clk(clk), .rst_n(rst_n), .bus_req(breq_a), .mem_rd(rd_a), .mem_wr(wr_a),
    .addr(addr_a), .wdata(wd_a), .gdel(gdel), .waitn(waitn), .bus_gnt(gnt_a),
    .mem_wait(wait_a), .rdata(mrd_a), .last_len(len_a), .last_lat(lat_a), .n_acc(acc_a),
    .cap_addr(cap_a), .last_waddr(wa_a), .last_wdata(wdv_a), .bad_strobe(bad_a),
    .req_bad(rqb_a), .both(both_a));

  int nd_s = 0, nd_a = 0, gcyc = 0, last_gap = 0;
  logic [15:0] got_s, got_a;
  logic breq_q = 1'b0;
  always @(posedge clk) begin
    if (done_s) begin nd_s <= nd_s + 1; got_s <= rdata_s; end
    if (done_a) begin nd_a <= nd_a + 1; got_a <= rdata_a; end
    breq_q <= breq_s;
    if (breq_s && !breq_q) begin last_gap <= gcyc; gcyc <= 1; end
    else gcyc <= gcyc + 1;
  end

  typedef struct packed {
    logic wr; logic tr; logic [4:0] sa; logic [4:0] wc;
    logic [15:0] data; logic [3:0] gd; logic [3:0] wn;
  } vec_t;
  localparam vec_t VEC [6] = '{
    '{1'b0, 1'b1, 5'd3,  5'd7,  16'h0000, 4'd0, 4'd0},
    '{1'b1, 1'b0, 5'd31, 5'd0,  16'hBEEF, 4'd2, 4'd1},
    '{1'b0, 1'b1, 5'd0,  5'd31, 16'h0000, 4'd1, 4'd5},
    '{1'b1, 1'b0, 5'd10, 5'd21, 16'h1234, 4'd0, 4'd2},
    '{1'b0, 1'b0, 5'd17, 5'd9,  16'h0000, 4'd3, 4'd3},
    '{1'b1, 1'b1, 5'd31, 5'd31, 16'hFFFF, 4'd0, 4'd6}
  };

  int n_chk = 0, n_fail = 0;
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] dev_word(input logic [10:0] a);
    return ({5'd0, a} * 16'd37) ^ 16'h5A3C;
  endfunction

  task automatic wait_both(input int s0, input int a0, input int k);
    while (nd_s < s0 + k || nd_a < a0 + k) @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    int s0, a0, es, ea;
    logic [10:0] ea_addr;
    gdel = v.gd; waitn = v.wn;
    while (busy_s || busy_a) @(negedge clk);
    s0 = nd_s; a0 = nd_a;
    xfer_valid = 1'b1; xfer_write = v.wr; xfer_tr = v.tr;
    xfer_sa = v.sa; xfer_wc = v.wc; xfer_wdata = v.data;
    @(negedge clk);
    xfer_valid = 1'b0;
    wait_both(s0, a0, 1);
    @(negedge clk);
    ea_addr = {v.tr, v.sa, v.wc};
    es = int'(v.wn) + 1;
    ea = (es > 4) ? es : 4;
    chk("R2 address sync", 32'(cap_s), 32'(ea_addr));
    chk("R2 address async", 32'(cap_a), 32'(ea_addr));
    chk("R3 grant-to-strobe latency sync", 32'(lat_s), 32'(int'(v.gd) + 1));
    chk("R3 grant-to-strobe latency async", 32'(lat_a), 32'(int'(v.gd) + 1));
    chk("R5 sync strobe length", 32'(len_s), 32'(es));
    chk("R6 async strobe length", 32'(len_a), 32'(ea));
    if (v.wr) begin
      chk("R9 write addr sync", 32'(wa_s), 32'(ea_addr));
      chk("R9 write data sync", 32'(wdv_s), 32'(v.data));
      chk("R9 write addr async", 32'(wa_a), 32'(ea_addr));
      chk("R9 write data async", 32'(wdv_a), 32'(v.data));
    end else begin
      chk("R5 sync read data", 32'(got_s), 32'(dev_word(ea_addr)));
      chk("R6 async read data", 32'(got_a), 32'(dev_word(ea_addr)));
    end
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int s0, a0, n0s, n0a;
    rst_n = 1'b0; xfer_valid = 1'b0; xfer_write = 1'b0; xfer_tr = 1'b0;
    xfer_sa = '0; xfer_wc = '0; xfer_wdata = '0; gdel = '0; waitn = '0;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", 32'({breq_s, rd_s, wr_s, busy_s, done_s, breq_a, rd_a, wr_a, busy_a, done_a}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs after reset", 32'({breq_s, rd_s, wr_s, busy_s, done_s, breq_a, rd_a, wr_a, busy_a, done_a}), 32'h0);

    for (int i = 0; i < 6; i++) run_vec(VEC[i]);

    repeat (120) @(negedge clk);
    gdel = 4'd0; waitn = 4'd0;
    s0 = nd_s; a0 = nd_a; n0s = acc_s; n0a = acc_a;
    xfer_valid = 1'b1; xfer_write = 1'b0; xfer_tr = 1'b0; xfer_sa = 5'd1; xfer_wc = 5'd1;
    @(negedge clk);
    xfer_valid = 1'b0;
    chk("R8 busy while slot full", 32'({busy_s, busy_a}), 32'h3);
    @(negedge clk);
    chk("R8 busy clear after launch", 32'({busy_s, busy_a}), 32'h0);
    xfer_valid = 1'b1; xfer_tr = 1'b1; xfer_sa = 5'd5; xfer_wc = 5'd2;
    @(negedge clk);
    chk("R8 busy with queued transfer", 32'({busy_s, busy_a}), 32'h3);
    xfer_tr = 1'b0; xfer_sa = 5'd9; xfer_wc = 5'd9;
    @(negedge clk);
    xfer_valid = 1'b0;
    wait_both(s0, a0, 2);
    repeat (150) @(negedge clk);
    chk("R8 dropped request sync count", 32'(acc_s - n0s), 32'd2);
    chk("R8 dropped request async count", 32'(acc_a - n0a), 32'd2);
    chk("R8 queued address reached memory", 32'(cap_s), 32'({1'b1, 5'd5, 5'd2}));
    chk("R9 one done per transfer", 32'(nd_s - s0), 32'd2);
    chk("R4 queued request spacing", 32'(last_gap), 32'd100);
    chk("R3 no strobe without grant", 32'({bad_s, bad_a}), 32'h0);
    chk("R7 request low after strobe", 32'({rqb_s, rqb_a}), 32'h0);
    chk("R10 strobes exclusive", 32'({both_s, both_a}), 32'h0);
    finish_run();
  end
endmodule